// File: doc/BRIEF.md
# ADC Sample/Convert Phase Sequencer

This block times the two phases of one successive-approximation conversion. A trigger starts an acquisition window. For that window the sample switch is held closed for a length set by a 3-bit code. Each channel keeps its own code, and the code of the selected channel is the one used. A fixed-length conversion window follows, with the busy output high. A one-cycle pulse marks the end of acquisition, and another marks the end of conversion. All timing is counted on a clock that runs at twice the converter clock, so half-cycle lengths are exact tick counts.

In presample mode the switch closes again as soon as a conversion finishes, and the next trigger only opens it and starts the conversion phase. The acquisition then lasts as long as the wait for that trigger, up to a parameter cap. The first conversion after enable always uses the code-timed window. Presample mode is refused, and a configuration error is raised, when continuous mode, trigger-timed sampling or an injected conversion is requested at the same time.

Top module: `adc_phase_seq`

## Requirements
- R1: The acquisition window, in ticks, for codes 0..7 is 5, 13, 25, 49, 95, 185, 495 and 1281. This is twice 2.5, 6.5, 12.5, 24.5, 47.5, 92.5, 247.5 and 640.5 converter cycles.
- R2: The code used is the one held by the channel on `chan_i` when the trigger is accepted. The code for channel k sits in bits [3k+2:3k] of `smp_code_i`.
- R3: The acquisition window is followed directly by `busy_o` held high for exactly CONV_TICKS ticks (25 by default), so with code 0 a conversion takes 30 ticks.
- R4: `samp_done_o` pulses for one cycle, in the first busy cycle. The pulse is suppressed when `injected_i` was high when the trigger was accepted.
- R5: `conv_done_o` pulses for one cycle, in the cycle after the last busy cycle.
- R6: With presample mode in effect, `samp_o` is high from the `conv_done_o` cycle onward. A trigger given in the n-th such cycle gives an acquisition of n ticks, and busy starts in the next cycle.
- R7: The first conversion after `en_i` rises uses the code-timed window (R1), even in presample mode.
- R8: If no trigger arrives within PRESAMP_MAX ticks of presampling, `samp_o` falls and `presamp_tmo_o` rises in the same cycle. The flag clears when the next trigger is accepted or when `en_i` is low, and that next trigger starts a code-timed conversion.
- R9: `cfg_err_o` is high while `presamp_i` is high together with `cont_mode_i`, `trig_samp_mode_i` or `injected_i`. Presample mode then has no effect: after a conversion `samp_o` stays low, and an ongoing presample stops.
- R10: A trigger while acquisition or conversion is in progress is ignored and sets the sticky `overrun_o`. A high `ovr_clr_i` clears it, and a new overrun wins over a clear in the same cycle.
- R11: Reset leaves all outputs low. While `en_i` is low the sequencer is idle from the next cycle and triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the converter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Sequencer enable |
| cont_mode_i | input | 1 | Continuous conversion mode requested |
| presamp_i | input | 1 | Presample mode requested |
| trig_samp_mode_i | input | 1 | Trigger-timed sampling mode requested |
| injected_i | input | 1 | Current conversion is injected |
| chan_i | input | CH_W | Channel select |
| smp_code_i | input | 3*N_CH | Per-channel sampling codes |
| trig_i | input | 1 | Conversion trigger |
| ovr_clr_i | input | 1 | Clear for overrun flag |
| samp_o | output | 1 | Sample switch enable |
| busy_o | output | 1 | Conversion phase active |
| samp_done_o | output | 1 | End-of-acquisition pulse |
| conv_done_o | output | 1 | End-of-conversion pulse |
| overrun_o | output | 1 | Sticky overrun flag |
| presamp_tmo_o | output | 1 | Presample cap reached |
| cfg_err_o | output | 1 | Illegal mode combination |

## Verification
The bench builds the block with four channels, a 25-tick conversion and a presample cap of 64 ticks. With four channels it can sweep every code on every channel, placing a different code on the others, and time each window against R1 to the exact tick. With the small cap, the timeout path and the recovery trigger after it can be reached in a few hundred cycles, alongside presample waits of 1 and 10 ticks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV, ST_PRE} seq_state_e;

  localparam int unsigned CODE_W    = 3;
  localparam int unsigned MAX_CODE_T = 1281;

  // half-cycle ticks per code
  function automatic logic [10:0] code_ticks(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 11'd5;
      3'd1:    return 11'd13;
      3'd2:    return 11'd25;
      3'd3:    return 11'd49;
      3'd4:    return 11'd95;
      3'd5:    return 11'd185;
      3'd6:    return 11'd495;
      default: return 11'd1281;
    endcase
  endfunction
endpackage

// File: rtl/adc_smp_sel.sv
module adc_smp_sel
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CH_W  = 2,
  parameter int unsigned CNT_W = 12
) (
  input  logic [CODE_W*N_CH-1:0] smp_code_i,
  input  logic [CH_W-1:0]        chan_i,
  output logic [CNT_W-1:0]       ticks_o
);
  logic [CODE_W-1:0] code_arr [N_CH];

  for (genvar k = 0; k < N_CH; k++) begin : g_unpack
    assign code_arr[k] = smp_code_i[k*CODE_W +: CODE_W];
  end

  always_comb begin
    ticks_o = CNT_W'(code_ticks('0));
    for (int k = 0; k < N_CH; k++) begin
      if (int'(chan_i) == k) ticks_o = CNT_W'(code_ticks(code_arr[k]));
    end
  end
endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned CONV_TICKS  = 25,
  parameter int unsigned PRESAMP_MAX = 2048
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic             injected_i,
  input  logic             pre_eff_i,
  input  logic [CNT_W-1:0] samp_ticks_i,
  output seq_state_e       state_o,
  output logic             samp_done_o,
  output logic             conv_done_o,
  output logic             accept_o,
  output logic             cap_o
);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TICKS - 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRESAMP_MAX - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             inj_q, inj_d;
  logic             sd_d, cd_d;
  logic             start_code;

  // code-timed start: from idle, or from a presample that is no longer allowed
  assign start_code = trig_i && ((st_q == ST_IDLE) || (st_q == ST_PRE && !pre_eff_i));

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    inj_d    = inj_q;
    sd_d     = 1'b0;
    cd_d     = 1'b0;
    cap_o    = 1'b0;
    accept_o = 1'b0;
    unique case (st_q)
      ST_IDLE: ;
      ST_SAMP: begin
        if (cnt_q == '0) begin
          st_d  = ST_CONV;
          cnt_d = CONV_LAST;
          sd_d  = ~inj_q;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_CONV: begin
        if (cnt_q == '0) begin
          cd_d  = 1'b1;
          cnt_d = '0;
          st_d  = pre_eff_i ? ST_PRE : ST_IDLE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_PRE: begin
        if (!pre_eff_i) begin
          st_d = ST_IDLE;
        end else if (trig_i) begin
          accept_o = 1'b1;
          inj_d    = injected_i;
          st_d     = ST_CONV;
          cnt_d    = CONV_LAST;
          sd_d     = ~injected_i;
        end else if (cnt_q == PRE_LAST) begin
          cap_o = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    endcase
    if (start_code) begin
      accept_o = 1'b1;
      inj_d    = injected_i;
      st_d     = ST_SAMP;
      cnt_d    = samp_ticks_i - ONE;
    end
    if (!en_i) begin
      st_d     = ST_IDLE;
      cnt_d    = '0;
      sd_d     = 1'b0;
      cd_d     = 1'b0;
      cap_o    = 1'b0;
      accept_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      inj_q       <= 1'b0;
      samp_done_o <= 1'b0;
      conv_done_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      inj_q       <= inj_d;
      samp_done_o <= sd_d;
      conv_done_o <= cd_d;
    end
  end

  assign state_o = st_q;

  // R6
  pre_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && st_q == ST_PRE && pre_eff_i && trig_i |=> st_q == ST_CONV);
endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trig_i,
  input  logic in_phase_i,
  input  logic ovr_clr_i,
  input  logic cap_i,
  input  logic accept_i,
  output logic overrun_o,
  output logic presamp_tmo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overrun_o     <= 1'b0;
      presamp_tmo_o <= 1'b0;
    end else begin
      if (en_i && trig_i && in_phase_i) overrun_o <= 1'b1;
      else if (ovr_clr_i)               overrun_o <= 1'b0;

      if (!en_i || accept_i) presamp_tmo_o <= 1'b0;
      else if (cap_i)        presamp_tmo_o <= 1'b1;
    end
  end

  // R10
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && trig_i && in_phase_i |=> overrun_o);
  // R10
  overrun_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i && !ovr_clr_i |=> $stable(overrun_o));
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned CONV_TICKS  = 25,
  parameter int unsigned PRESAMP_MAX = 2048,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned MAX_A = (CONV_TICKS > MAX_CODE_T) ? CONV_TICKS : MAX_CODE_T,
  localparam int unsigned MAX_T = (PRESAMP_MAX > MAX_A) ? PRESAMP_MAX : MAX_A,
  localparam int unsigned CNT_W = $clog2(MAX_T + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   cont_mode_i,
  input  logic                   presamp_i,
  input  logic                   trig_samp_mode_i,
  input  logic                   injected_i,
  input  logic [CH_W-1:0]        chan_i,
  input  logic [CODE_W*N_CH-1:0] smp_code_i,
  input  logic                   trig_i,
  input  logic                   ovr_clr_i,
  output logic                   samp_o,
  output logic                   busy_o,
  output logic                   samp_done_o,
  output logic                   conv_done_o,
  output logic                   overrun_o,
  output logic                   presamp_tmo_o,
  output logic                   cfg_err_o
);
  seq_state_e       state;
  logic [CNT_W-1:0] samp_ticks;
  logic             pre_eff, accept, cap;

  assign cfg_err_o = presamp_i && (cont_mode_i || trig_samp_mode_i || injected_i);
  assign pre_eff   = presamp_i && !cfg_err_o;

  adc_smp_sel #(.N_CH(N_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_sel (
    .smp_code_i (smp_code_i),
    .chan_i     (chan_i),
    .ticks_o    (samp_ticks)
  );

  adc_phase_ctrl #(.CNT_W(CNT_W), .CONV_TICKS(CONV_TICKS), .PRESAMP_MAX(PRESAMP_MAX)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .trig_i       (trig_i),
    .injected_i   (injected_i),
    .pre_eff_i    (pre_eff),
    .samp_ticks_i (samp_ticks),
    .state_o      (state),
    .samp_done_o  (samp_done_o),
    .conv_done_o  (conv_done_o),
    .accept_o     (accept),
    .cap_o        (cap)
  );

  assign samp_o = (state == ST_SAMP) || (state == ST_PRE);
  assign busy_o = (state == ST_CONV);

  adc_seq_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .trig_i        (trig_i),
    .in_phase_i    ((state == ST_SAMP) || (state == ST_CONV)),
    .ovr_clr_i     (ovr_clr_i),
    .cap_i         (cap),
    .accept_i      (accept),
    .overrun_o     (overrun_o),
    .presamp_tmo_o (presamp_tmo_o)
  );

  // R4
  samp_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_done_o |-> busy_o && $past(samp_o));
  // R5
  conv_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> $past(busy_o) && !busy_o);
  // R5
  conv_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) && $past(en_i) |-> conv_done_o);
  // R11
  disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !samp_o && !busy_o && !conv_done_o);
  // R8
  tmo_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(presamp_tmo_o) |-> $fell(samp_o));
endmodule

// File: tb/sim_adc_phase_seq.sv
module sim_adc_phase_seq;
  localparam int N_CH = 4;
  localparam int CONV = 25;
  localparam int PMAX = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, cont = 1'b0, pre = 1'b0, tsm = 1'b0, inj = 1'b0;
  logic [1:0] chan = '0;
  logic [3*N_CH-1:0] codes = '0;
  logic trig = 1'b0, oclr = 1'b0;
  logic samp, busy, sdone, cdone, ovr, tmo, cerr;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  adc_phase_seq #(.N_CH(N_CH), .CONV_TICKS(CONV), .PRESAMP_MAX(PMAX)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cont_mode_i(cont), .presamp_i(pre),
    .trig_samp_mode_i(tsm), .injected_i(inj), .chan_i(chan), .smp_code_i(codes),
    .trig_i(trig), .ovr_clr_i(oclr), .samp_o(samp), .busy_o(busy),
    .samp_done_o(sdone), .conv_done_o(cdone), .overrun_o(ovr),
    .presamp_tmo_o(tmo), .cfg_err_o(cerr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int code);
    int cyc;
    case (code)
      0: cyc = 2;   1: cyc = 6;   2: cyc = 12;  3: cyc = 24;
      4: cyc = 47;  5: cyc = 92;  6: cyc = 247; default: cyc = 640;
    endcase
    return 2 * cyc + 1; // cyc + 0.5 converter cycles, in half-cycle ticks
  endfunction

  task automatic fire(input int ch, input logic ij);
    @(negedge clk);
    chan = 2'(ch); inj = ij; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic meas_samp(output int ns);
    ns = 0;
    while (samp) begin ns++; @(negedge clk); end
  endtask

  task automatic meas_busy(output int nb, output int sd_first, output int n_sd, output int cd);
    nb = 0; n_sd = 0;
    sd_first = int'(sdone);
    while (busy) begin
      nb++; n_sd += int'(sdone);
      @(negedge clk);
    end
    cd = int'(cdone);
  endtask

  task automatic pre_hold(input int w, output int n);
    n = 0;
    while (samp) begin
      n++;
      if (n == w) trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int ns, nb, sdf, nsd, cd, n;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset samp", int'(samp), 0);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset flags", int'({sdone, cdone, ovr, tmo, cerr}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    en = 1'b1;

    // R1 R2 R3 R4 R5: every code on every channel
    for (int ch = 0; ch < N_CH; ch++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < N_CH; k++) codes[3*k +: 3] = (k == ch) ? 3'(c) : 3'(7 - c);
        fire(ch, 1'b0);
        meas_samp(ns);
        chk("R1 R2 sample ticks", ns, exp_ticks(c));
        meas_busy(nb, sdf, nsd, cd);
        chk("R3 busy ticks", nb, CONV);
        chk("R4 samp_done first busy cycle", sdf, 1);
        chk("R4 samp_done single", nsd, 1);
        chk("R5 conv_done after busy", cd, 1);
        @(negedge clk);
        chk("R5 conv_done one cycle", int'(cdone), 0);
      end
    end
    chk("R10 no overrun on clean runs", int'(ovr), 0);

    // R4 injected: no end-of-acquisition pulse
    codes = 12'h0;
    fire(0, 1'b1);
    meas_samp(ns);
    chk("R4 injected sample ticks", ns, 5);
    meas_busy(nb, sdf, nsd, cd);
    inj = 1'b0;
    chk("R4 injected samp_done", nsd, 0);
    chk("R5 injected conv_done", cd, 1);

    // R10 overrun
    @(negedge clk);
    chan = 2'd0; trig = 1'b1;
    @(negedge clk);
    ns = 0;
    while (samp) begin ns++; @(negedge clk); trig = 1'b0; end
    chk("R10 overrun set", int'(ovr), 1);
    chk("R10 ignored trigger sample ticks", ns, 5);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    nb = 1;
    while (busy) begin nb++; @(negedge clk); end
    chk("R10 ignored trigger busy ticks", nb, CONV);
    chk("R10 overrun sticky", int'(ovr), 1);
    oclr = 1'b1;
    @(negedge clk);
    oclr = 1'b0;
    chk("R10 overrun cleared", int'(ovr), 0);

    // R6 R7 R8 presample mode
    codes[2:0] = 3'd3;
    en = 1'b0;
    @(negedge clk);
    en = 1'b1; pre = 1'b1;
    fire(0, 1'b0);
    meas_samp(ns);
    chk("R7 first after enable code timed", ns, 49);
    meas_busy(nb, sdf, nsd, cd);
    chk("R6 samp in conv_done cycle", int'(samp), 1);
    pre_hold(10, n);
    chk("R6 presample ticks 10", n, 10);
    meas_busy(nb, sdf, nsd, cd);
    chk("R6 busy after presample", nb, CONV);
    chk("R4 presample samp_done", sdf, 1);
    chk("R5 presample conv_done", cd, 1);
    pre_hold(1, n);
    chk("R6 presample ticks 1", n, 1);
    meas_busy(nb, sdf, nsd, cd);
    pre_hold(1000, n);
    chk("R8 presample capped", n, PMAX);
    chk("R8 timeout flag", int'(tmo), 1);
    fire(0, 1'b0);
    chk("R8 timeout cleared on accept", int'(tmo), 0);
    meas_samp(ns);
    chk("R8 code timed after timeout", ns, 49);
    meas_busy(nb, sdf, nsd, cd);
    chk("R6 presample resumes", int'(samp), 1);

    // R11 disable drops presample, R7 re-enable
    en = 1'b0;
    @(negedge clk);
    chk("R11 disable idles", int'(samp | busy), 0);
    en = 1'b1;
    fire(0, 1'b0);
    meas_samp(ns);
    chk("R7 code timed after re-enable", ns, 49);
    meas_busy(nb, sdf, nsd, cd);
    chk("R6 presample after re-enable", int'(samp), 1);

    // R9 illegal combinations
    cont = 1'b1;
    #1;
    chk("R9 cfg_err continuous", int'(cerr), 1);
    @(negedge clk);
    chk("R9 presample stopped", int'(samp), 0);
    fire(0, 1'b0);
    meas_samp(ns);
    meas_busy(nb, sdf, nsd, cd);
    chk("R9 no presample with continuous", int'(samp), 0);
    cont = 1'b0; tsm = 1'b1;
    #1;
    chk("R9 cfg_err trigger-timed sampling", int'(cerr), 1);
    tsm = 1'b0; inj = 1'b1;
    #1;
    chk("R9 cfg_err injected", int'(cerr), 1);
    fire(0, 1'b1);
    meas_samp(ns);
    chk("R9 injected sample ticks", ns, 49);
    meas_busy(nb, sdf, nsd, cd);
    chk("R9 no presample with injected", int'(samp), 0);
    inj = 1'b0;
    #1;
    chk("R9 cfg_err clear", int'(cerr), 0);

    // R11 disable mid-acquisition, triggers ignored while disabled
    pre = 1'b0;
    fire(0, 1'b0);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R11 disable mid-acquisition", int'(samp | busy), 0);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R11 trigger ignored when disabled", int'(samp | busy), 0);
    chk("R10 no overrun when disabled", int'(ovr), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule